// File: doc/BRIEF.md
# Control Port Write Decoder

This block sits behind a byte-oriented serial control interface. The interface delivers received bytes one at a time, and marks where each transaction begins and ends. The block turns that byte stream into word writes aimed at one of three targets: a coefficient RAM, an instruction RAM or a small register file.

Each transaction opens with three header bytes:
- a device address with a direction bit,
- the high part of an 11-bit location,
- the low part of that location.

Data bytes follow the header. The location decides how many bytes make one word. Once a word is complete, the block issues a single write strobe with the target, address and data, all registered.

Further words in the same transaction go to the following locations, with no new header. The byte count per word is chosen again for each word, from the address that word lands on. Locations in the reserved window consume bytes but never produce a write.

Top module: `ctrl_write_decoder`

## Requirements
- R1: Header byte 0 carries the device address in bits 7:1 and the direction in bit 0 (0 = write). If bits 7:1 differ from `dev_addr_cfg`, or bit 0 is 1, no write is issued for the rest of that transaction.
- R2: Header byte 1 supplies address bits 10:8 from its bits 2:0, and header byte 2 supplies address bits 7:0. Bits 7:3 of header byte 1 have no effect.
- R3: Addresses 0..1023 are coefficient RAM (`wr_target` = 0).
  - Each word is 4 bytes, most significant first.
  - The top 4 bits of the first byte are dropped.
  - `wr_data` carries the 28-bit value with bits 39:28 zero.
- R4: Addresses 1024..1535 are instruction RAM (`wr_target` = 1). Each word is 5 bytes, most significant first, and all 40 bits reach `wr_data`.
- R5: Addresses from `REG_BASE` (default 2032) to 2047 are registers (`wr_target` = 2). Each word is 1 byte, placed in `wr_data` bits 7:0 with the upper bits zero.
- R6: Addresses 1536 up to `REG_BASE`-1 are reserved. Each such location consumes one byte, produces no strobe, and the address still advances.
- R7: `wr_strobe` is high for exactly one cycle: the cycle after the clock edge that samples a word's final byte. `wr_target`, `wr_addr` and `wr_data` are valid in that same cycle.
- R8: Within a transaction, each following word goes to the previous address plus one, wrapping from 2047 to 0. Its byte count follows the region of its own address.
- R9: When `txn_end` arrives partway through a word, the partial word is dropped. Bytes arriving after `txn_end` and before the next `txn_start` are ignored.
- R10: A byte sampled together with `txn_end` is processed before the transaction closes, so it can complete a word. A byte sampled together with `txn_start` is taken as header byte 0, and any word in progress is abandoned.
- R11: After reset, `wr_strobe` is low and bytes are ignored until a `txn_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| byte_valid | input | 1 | A received byte is present this cycle |
| byte_data | input | 8 | The received byte |
| txn_start | input | 1 | First cycle of a transaction |
| txn_end | input | 1 | Transaction closes after this cycle |
| dev_addr_cfg | input | 7 | Device address this block answers to |
| wr_strobe | output | 1 | One-cycle write command |
| wr_target | output | 2 | 0 coefficient RAM, 1 instruction RAM, 2 register |
| wr_addr | output | 11 | Word address of the write |
| wr_data | output | 40 | Word data, right-aligned, unused upper bits zero |

## Verification
Completing a word and closing the transaction can happen in the same cycle. This is provoked by marking every transaction's last byte with `txn_end`. The check is that the word is still written, and that the next stray byte produces nothing.

Opening a transaction can also coincide with a byte. This is provoked by raising `txn_start` together with the device byte, including once while a word is half assembled. The check is that only words from the new header appear.

Bursts that cross region boundaries and the top-of-space wrap are compared, word by word, against an arithmetic walk of the address map computed in the bench.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
  typedef enum logic [1:0] {
    TGT_PARAM = 2'd0,
    TGT_PROG  = 2'd1,
    TGT_REG   = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEV  = 3'd1,
    ST_AHI  = 3'd2,
    ST_ALO  = 3'd3,
    ST_DATA = 3'd4
  } st_e;
endpackage

// File: rtl/cwd_region.sv
module cwd_region
  import cwd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PARAM_END   = 1024,
  parameter int PROG_END    = 1536,
  parameter int REG_BASE    = 2032,
  parameter int PARAM_BYTES = 4,
  parameter int PROG_BYTES  = 5,
  parameter int CNT_W       = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [CNT_W-1:0]  nbytes
);
  always_comb begin
    if (addr < ADDR_W'(PARAM_END)) begin
      tgt    = TGT_PARAM;
      nbytes = CNT_W'(PARAM_BYTES);
    end else if (addr < ADDR_W'(PROG_END)) begin
      tgt    = TGT_PROG;
      nbytes = CNT_W'(PROG_BYTES);
    end else if (addr >= ADDR_W'(REG_BASE)) begin
      tgt    = TGT_REG;
      nbytes = CNT_W'(1);
    end else begin
      tgt    = TGT_NONE;
      nbytes = CNT_W'(1);
    end
  end
endmodule

// File: rtl/cwd_assembler.sv
module cwd_assembler #(
  parameter int MAXB  = 5,
  parameter int CNT_W = 3,
  localparam int W    = MAXB * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic [7:0]       byte_in,
  output logic [W-1:0]     shift_word,
  output logic [CNT_W-1:0] cnt_inc
);
  logic [W-1:0]     word_q, word_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign shift_word = {word_q[W-9:0], byte_in};
  assign cnt_inc    = cnt_q + CNT_W'(1);

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr) begin
      word_d = '0;
      cnt_d  = '0;
    end else if (shift) begin
      word_d = shift_word;
      cnt_d  = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr || shift) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/ctrl_write_decoder.sv
module ctrl_write_decoder
  import cwd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PARAM_END   = 1024,
  parameter int PROG_END    = 1536,
  parameter int REG_BASE    = 2032,
  parameter int PARAM_BYTES = 4,
  parameter int PROG_BYTES  = 5,
  parameter int PARAM_VAL_W = 28
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  input  logic                    txn_start,
  input  logic                    txn_end,
  input  logic [6:0]              dev_addr_cfg,
  output logic                    wr_strobe,
  output logic [1:0]              wr_target,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [PROG_BYTES*8-1:0] wr_data
);
  localparam int WORD_W = PROG_BYTES * 8;
  localparam int CNT_W  = $clog2(PROG_BYTES + 1);

  // reset synchroniser: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  st_e               st_q, st_d, eff_st;
  logic [ADDR_W-1:0] addr_q, addr_d;
  tgt_e              tgt;
  logic [CNT_W-1:0]  nbytes, cnt_inc;
  logic [WORD_W-1:0] shift_word, wdata_d;
  logic              shift, clr, wr_d;

  logic              wr_q;
  tgt_e              tgt_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [WORD_W-1:0] wdata_q;

  cwd_region #(
    .ADDR_W(ADDR_W), .PARAM_END(PARAM_END), .PROG_END(PROG_END),
    .REG_BASE(REG_BASE), .PARAM_BYTES(PARAM_BYTES),
    .PROG_BYTES(PROG_BYTES), .CNT_W(CNT_W)
  ) u_region (
    .addr(addr_q), .tgt(tgt), .nbytes(nbytes)
  );

  cwd_assembler #(.MAXB(PROG_BYTES), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .shift(shift),
    .byte_in(byte_data), .shift_word(shift_word), .cnt_inc(cnt_inc)
  );

  // a start marker forces the byte of the same cycle into the device slot
  assign eff_st = txn_start ? ST_DEV : st_q;

  always_comb begin
    st_d   = eff_st;
    addr_d = addr_q;
    shift  = 1'b0;
    clr    = txn_start;
    wr_d   = 1'b0;
    if (byte_valid) begin
      case (eff_st)
        ST_DEV: st_d = (byte_data[7:1] == dev_addr_cfg && !byte_data[0])
                       ? ST_AHI : ST_IDLE;
        ST_AHI: begin
          addr_d = {byte_data[ADDR_W-9:0], addr_q[7:0]};
          st_d   = ST_ALO;
        end
        ST_ALO: begin
          addr_d[7:0] = byte_data;
          st_d        = ST_DATA;
          clr         = 1'b1;
        end
        ST_DATA: begin
          if (cnt_inc == nbytes) begin
            wr_d   = (tgt != TGT_NONE);
            clr    = 1'b1;
            addr_d = addr_q + ADDR_W'(1);
          end else begin
            shift = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    if (txn_end) begin
      st_d = ST_IDLE;
      clr  = 1'b1;
    end
  end

  always_comb begin
    case (tgt)
      TGT_PARAM: wdata_d = WORD_W'(shift_word[PARAM_VAL_W-1:0]);
      TGT_REG:   wdata_d = WORD_W'(shift_word[7:0]);
      default:   wdata_d = shift_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_q    <= 1'b0;
      tgt_q   <= TGT_PARAM;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      wr_q <= wr_d;
      if (wr_d) begin
        tgt_q   <= tgt;
        waddr_q <= addr_q;
        wdata_q <= wdata_d;
      end
    end
  end

  assign wr_strobe = wr_q;
  assign wr_target = tgt_q;
  assign wr_addr   = waddr_q;
  assign wr_data   = wdata_q;
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int ADDR_W      = 11,
  parameter int PARAM_END   = 1024,
  parameter int PROG_END    = 1536,
  parameter int REG_BASE    = 2032,
  parameter int WORD_W      = 40,
  parameter int PARAM_VAL_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic              txn_start,
  input logic              txn_end,
  input logic              wr_strobe,
  input logic [1:0]        wr_target,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data
);
  assert_no_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> wr_target != 2'd3);

  assert_param_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_target == 2'd0) |->
      (wr_data[WORD_W-1:PARAM_VAL_W] == '0 && wr_addr < ADDR_W'(PARAM_END)));

  assert_prog_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_target == 2'd1) |->
      (wr_addr >= ADDR_W'(PARAM_END) && wr_addr < ADDR_W'(PROG_END)));

  assert_reg_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_target == 2'd2) |->
      (wr_data[WORD_W-1:8] == '0 && wr_addr >= ADDR_W'(REG_BASE)));

  assert_strobe_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !wr_strobe);

  assert_burst_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && $past(wr_strobe) && wr_target == 2'd2 && $past(wr_target) == 2'd2)
      |-> wr_addr == $past(wr_addr) + ADDR_W'(1));

  assert_closed_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_end && !txn_start) ##1 (byte_valid && !txn_start) |=> !wr_strobe);
endmodule

bind ctrl_write_decoder cwd_checker #(
  .ADDR_W(ADDR_W), .PARAM_END(PARAM_END), .PROG_END(PROG_END),
  .REG_BASE(REG_BASE), .WORD_W(PROG_BYTES*8), .PARAM_VAL_W(PARAM_VAL_W)
) u_cwd_chk (
  .clk(clk), .rst_n(rst_sync_n), .byte_valid(byte_valid),
  .txn_start(txn_start), .txn_end(txn_end), .wr_strobe(wr_strobe),
  .wr_target(wr_target), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/ctrl_write_decoder_test.sv
module ctrl_write_decoder_test;
  localparam logic [6:0] DEV = 7'h34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid, txn_start, txn_end;
  logic [7:0]  byte_data;
  logic        wr_strobe;
  logic [1:0]  wr_target;
  logic [10:0] wr_addr;
  logic [39:0] wr_data;

  int errors = 0;
  int checks = 0;

  logic [1:0]  c_tgt  [1024];
  logic [10:0] c_addr [1024];
  logic [39:0] c_data [1024];
  int ncap = 0;

  logic [7:0] pay [64];

  always #10 clk = ~clk;

  ctrl_write_decoder uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .txn_start(txn_start), .txn_end(txn_end), .dev_addr_cfg(DEV),
    .wr_strobe(wr_strobe), .wr_target(wr_target), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (rst_n && wr_strobe && ncap < 1024) begin
      c_tgt[ncap]  = wr_target;
      c_addr[ncap] = wr_addr;
      c_data[ncap] = wr_data;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic s, input logic e);
    @(negedge clk);
    byte_valid = 1'b1; byte_data = b; txn_start = s; txn_end = e;
  endtask

  task automatic rest(input int n);
    @(negedge clk);
    byte_valid = 1'b0; byte_data = 8'h00; txn_start = 1'b0; txn_end = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic hdr(input logic [6:0] dev, input logic rw, input int a, input logic [4:0] junk);
    put({dev, rw}, 1'b1, 1'b0);
    put({junk, 3'(a >> 8)}, 1'b0, 1'b0);
    put(8'(a), 1'b0, 1'b0);
  endtask

  function automatic int need(input int a);
    if (a < 1024) return 4;
    if (a < 1536) return 5;
    return 1;
  endfunction

  function automatic int region(input int a);
    if (a < 1024) return 0;
    if (a < 1536) return 1;
    if (a < 2032) return 3;
    return 2;
  endfunction

  // header, n payload bytes with txn_end on the last, then compare with an address-map walk
  task automatic burst(input string tag, input logic [6:0] dev, input logic rw,
                       input int a0, input logic [4:0] junk, input int n, input int seed);
    int base, nexp, a, idx;
    logic [39:0] v;
    base = ncap;
    for (int k = 0; k < n; k++) pay[k] = 8'((seed * 41 + k * 97 + 13) ^ (k * 5));
    hdr(dev, rw, a0, junk);
    for (int k = 0; k < n; k++) put(pay[k], 1'b0, k == n - 1);
    rest(4);
    nexp = 0; a = a0; idx = 0;
    if (dev == DEV && !rw) begin
      while (idx + need(a) <= n) begin
        v = '0;
        for (int k = 0; k < need(a); k++) v = (v << 8) | 40'(pay[idx + k]);
        if (region(a) == 0) v = v & 40'h000FFFFFFF;
        idx += need(a);
        if (region(a) != 3) begin
          if (base + nexp < ncap) begin
            chk({tag, " target"}, 64'(c_tgt[base + nexp]), 64'(region(a)));
            chk({tag, " addr"},   64'(c_addr[base + nexp]), 64'(a));
            chk({tag, " data"},   64'(c_data[base + nexp]), 64'(v));
          end
          nexp++;
        end
        a = (a + 1) % 2048;
      end
    end
    chk({tag, " write count"}, 64'(ncap - base), 64'(nexp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = 8'h00; txn_start = 1'b0; txn_end = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rest(4);
    chk("R11 strobe low after reset", 64'(wr_strobe), 64'd0);

    // R11: bytes before any start are ignored
    base = ncap;
    for (int k = 0; k < 6; k++) put(8'(k + 8'h60), 1'b0, 1'b0);
    rest(3);
    chk("R11 no write before start", 64'(ncap - base), 64'd0);

    // R3: coefficient region sweep, first byte has high nibble set
    for (int a = 0; a < 1024; a += 93) burst("R3 coeff", DEV, 1'b0, a, 5'd0, 4, a);
    burst("R3 coeff top", DEV, 1'b0, 1023, 5'd0, 4, 7);

    // R4: instruction region sweep
    for (int a = 1024; a < 1536; a += 71) burst("R4 instr", DEV, 1'b0, a, 5'd0, 5, a);
    burst("R4 instr top", DEV, 1'b0, 1535, 5'd0, 5, 3);

    // R5: every register location
    for (int a = 2032; a < 2048; a++) burst("R5 reg", DEV, 1'b0, a, 5'd0, 1, a);

    // R6: reserved window consumes bytes silently
    for (int a = 1536; a < 2032; a += 97) burst("R6 reserved", DEV, 1'b0, a, 5'd0, 3, a);
    burst("R6 reserved into regs", DEV, 1'b0, 2029, 5'd0, 5, 11);

    // R8: bursts across region edges and the top-of-space wrap
    burst("R8 coeff to instr", DEV, 1'b0, 1022, 5'd0, 18, 21);
    burst("R8 wrap to zero", DEV, 1'b0, 2046, 5'd0, 6, 22);
    burst("R8 instr to reserved", DEV, 1'b0, 1534, 5'd0, 13, 23);

    // R2: upper bits of the high address byte
    burst("R2 junk bits", DEV, 1'b0, 700, 5'h1F, 4, 31);
    burst("R2 junk bits reg", DEV, 1'b0, 2040, 5'h15, 2, 32);

    // R1: foreign device and read direction
    burst("R1 other device", DEV ^ 7'h01, 1'b0, 100, 5'd0, 8, 41);
    burst("R1 read request", DEV, 1'b1, 100, 5'd0, 8, 42);

    // R9: partial word dropped, then stray bytes after the end
    burst("R9 partial tail", DEV, 1'b0, 1000, 5'd0, 7, 51);
    burst("R9 short word", DEV, 1'b0, 300, 5'd0, 3, 52);
    base = ncap;
    for (int k = 0; k < 5; k++) put(8'hA0 + 8'(k), 1'b0, 1'b0);
    rest(3);
    chk("R9 bytes after end ignored", 64'(ncap - base), 64'd0);

    // R10: new start abandons a half-built word
    base = ncap;
    hdr(DEV, 1'b0, 100, 5'd0);
    put(8'h11, 1'b0, 1'b0);
    put(8'h22, 1'b0, 1'b0);
    hdr(DEV, 1'b0, 200, 5'd0);
    put(8'hF1, 1'b0, 1'b0);
    put(8'h23, 1'b0, 1'b0);
    put(8'h45, 1'b0, 1'b0);
    put(8'h67, 1'b0, 1'b1);
    rest(4);
    chk("R10 restart count", 64'(ncap - base), 64'd1);
    chk("R10 restart addr", 64'(c_addr[base]), 64'd200);
    chk("R10 restart data", 64'(c_data[base]), 64'h0001234567);

    // R7: strobe timing against the final byte (sampled with txn_end, R10)
    hdr(DEV, 1'b0, 2040, 5'd0);
    put(8'h5A, 1'b0, 1'b1);
    rest(1);
    chk("R7 strobe one cycle after last byte", 64'(wr_strobe), 64'd1);
    chk("R7 addr with strobe", 64'(wr_addr), 64'd2040);
    chk("R10 byte with end completes word", 64'(wr_data), 64'h5A);
    @(negedge clk);
    chk("R7 strobe drops after one cycle", 64'(wr_strobe), 64'd0);

    rest(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule